// File: doc/BRIEF.md
# Error Counters and Fault Confinement for a CAN-Style Node

This block keeps the two error counters of a CAN-style node, one for transmission and one for reception, and derives the node's fault-confinement state from them. The protocol engine feeds it single-cycle pulses: a transmit or receive error, and a successful transmit or receive. The block raises a warning flag once either counter reaches a programmable limit. It reports the error-passive state above 127. It enters bus-off when the transmit counter would pass 255.

Each error pulse also records a one-byte capture. The capture holds the error kind, whether the node was sending or receiving, and the frame segment in which the error was seen. A small register port reads the counters, the limit and the capture. While the node is held in reset mode, the same port can load the counters and the limit. Reset mode is also the only way out of bus-off.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, both counters and the capture byte are 0, the warning limit is 96, and `warn_o`, `passive_o` and `bus_off_o` are 0.
- R2: In operating mode (`reset_mode_i`=0, `listen_only_i`=0, not bus-off), `tx_err_i` adds 8 to the transmit counter and `rx_err_i` adds 1 to the receive counter. When an error pulse and a success pulse for the same counter arrive in the same cycle, the error wins. Each change is visible on the next cycle.
- R3: Under the same conditions, `tx_ok_i` and `rx_ok_i` each subtract 1 from their own counter. A counter at 0 stays at 0.
- R4: `warn_o` is 1 exactly when at least one counter is greater than or equal to the warning limit.
- R5: `passive_o` is 1 exactly when at least one counter exceeds 127 and the node is not bus-off.
- R6: A transmit error that would take the transmit counter above 255 sets `bus_off_o` on the next cycle and leaves that counter at 255. While the node is bus-off, both counters ignore all event pulses.
- R7: `bus_off_o` stays set until a cycle in which `reset_mode_i` is 1. That cycle clears both counters and `bus_off_o`, and this clear takes priority over a register write in the same cycle.
- R8: While `listen_only_i` is 1, both counters hold their values whatever the event pulses do.
- R9: A write (`reg_wr_i`=1) updates the transmit counter (address 0), the receive counter (address 1) or the warning limit (address 2) on the next cycle, but only while `reset_mode_i` is 1. In operating mode, writes have no effect. Address 3 (the capture) is never writable.
- R10: `reg_rdata_o` combinationally returns the transmit counter at address 0, the receive counter at address 1, the warning limit at address 2 and the capture byte at address 3.
- R11: When `reset_mode_i` is 0, every error pulse loads the capture byte on the next cycle with the following fields:
  - bits 7:6: `err_kind_i`, where 00 is a bit error, 01 a form error, 10 a stuff error and 11 any other error;
  - bit 5: the direction, 1 for a receive error and 0 for a transmit error;
  - bits 4:0: `err_seg_i`.
  When both error pulses arrive together, the transmit direction (0) is recorded.
- R12: While `reset_mode_i` is 1, event pulses change neither the counters nor the capture byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_mode_i | input | 1 | Node held in reset mode |
| listen_only_i | input | 1 | Listen-only mode, freezes the counters |
| tx_err_i | input | 1 | Error pulse while transmitting |
| rx_err_i | input | 1 | Error pulse while receiving |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| err_kind_i | input | 2 | Kind of the signalled error |
| err_seg_i | input | 5 | Frame segment of the signalled error |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| warn_o | output | 1 | A counter is at or above the warning limit |
| passive_o | output | 1 | Error-passive state |
| bus_off_o | output | 1 | Bus-off state |
| err_capture_o | output | 8 | Last captured error code |

## Verification
The assertions check every cycle for the following:
- a counter at zero never wraps below it on a success pulse;
- frozen counters stay frozen in listen-only mode, in reset mode and in bus-off;
- bus-off is entered right after a transmit overflow and is left only through reset mode;
- the limit does not move outside reset mode;
- the capture records the right direction and is frozen in reset mode.

Other behaviour is shown only by the bench's scenarios:
- the exact step sizes of the counters;
- the warning and passive thresholds, including the equal-to-limit and 127/128 edges;
- the 248-to-bus-off boundary;
- clear-over-write priority on leaving bus-off;
- the field layout of the capture byte.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    ERR_BIT   = 2'b00,
    ERR_FORM  = 2'b01,
    ERR_STUFF = 2'b10,
    ERR_OTHER = 2'b11
  } err_kind_e;

  typedef enum logic [1:0] {
    ADDR_TXCNT = 2'd0,
    ADDR_RXCNT = 2'd1,
    ADDR_LIMIT = 2'd2,
    ADDR_CAPT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ERR_INC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             hold_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(ERR_INC);
  assign ovf_o = err_i && !hold_i && sum[CNT_W];
  assign cnt_o = cnt_q;

  // priority: clear, write, freeze, error, success
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (wr_en_i)        cnt_q <= wr_data_i;
    else if (!hold_i) begin
      if (err_i)             cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      else if (ok_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && !err_i && !hold_i && !wr_en_i && !clear_i && cnt_q == '0) |=> cnt_q == '0);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i && !wr_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/can_fc_capture.sv
module can_fc_capture
  import can_fc_pkg::*;
#(
  parameter int unsigned SEG_W = 5,
  localparam int unsigned CAP_W = SEG_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  err_kind_e        kind_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic [CAP_W-1:0] cap_o
);
  logic [CAP_W-1:0] cap_q;

  // transmit direction wins when both pulses coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else if (en_i && (tx_err_i || rx_err_i))
      cap_q <= {kind_i, !tx_err_i, seg_i};
  end

  assign cap_o = cap_q;

  assert_tx_dir_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_err_i) |=> !cap_q[SEG_W]);

  assert_rx_dir_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_err_i && !tx_err_i) |=> cap_q[SEG_W]);

  assert_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cap_q));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SEG_W       = 5,
  parameter int unsigned TX_ERR_INC  = 8,
  parameter int unsigned RX_ERR_INC  = 1,
  parameter int unsigned PASSIVE_THR = 127,
  parameter int unsigned LIMIT_RST   = 96,
  localparam int unsigned CAP_W = SEG_W + 3,
  localparam int unsigned DW    = (CNT_W > CAP_W) ? CNT_W : CAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_mode_i,
  input  logic             listen_only_i,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic [1:0]       err_kind_i,
  input  logic [SEG_W-1:0] err_seg_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             bus_off_o,
  output logic [CAP_W-1:0] err_capture_o
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt, limit_q;
  logic             bus_off_q, tx_ovf, rx_ovf_unused;
  logic             hold, clear, wr_ok;
  logic [CNT_W-1:0] wdata;

  assign hold  = reset_mode_i || listen_only_i || bus_off_q;
  assign clear = reset_mode_i && bus_off_q;
  assign wr_ok = reg_wr_i && reset_mode_i;
  assign wdata = reg_wdata_i[CNT_W-1:0];

  can_fc_counter #(.CNT_W(CNT_W), .ERR_INC(TX_ERR_INC)) i_tx_cnt (
    .clk_i, .rst_ni, .clear_i(clear), .hold_i(hold),
    .wr_en_i(wr_ok && reg_addr_i == ADDR_TXCNT), .wr_data_i(wdata),
    .err_i(tx_err_i), .ok_i(tx_ok_i), .cnt_o(tx_cnt), .ovf_o(tx_ovf)
  );

  // receive overflow saturates only, it never leads to bus-off
  can_fc_counter #(.CNT_W(CNT_W), .ERR_INC(RX_ERR_INC)) i_rx_cnt (
    .clk_i, .rst_ni, .clear_i(clear), .hold_i(hold),
    .wr_en_i(wr_ok && reg_addr_i == ADDR_RXCNT), .wr_data_i(wdata),
    .err_i(rx_err_i), .ok_i(rx_ok_i), .cnt_o(rx_cnt), .ovf_o(rx_ovf_unused)
  );

  can_fc_capture #(.SEG_W(SEG_W)) i_capture (
    .clk_i, .rst_ni, .en_i(!reset_mode_i),
    .tx_err_i, .rx_err_i, .kind_i(err_kind_e'(err_kind_i)), .seg_i(err_seg_i),
    .cap_o(err_capture_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  limit_q <= CNT_W'(LIMIT_RST);
    else if (wr_ok && reg_addr_i == ADDR_LIMIT)   limit_q <= wdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bus_off_q <= 1'b0;
    else if (clear)  bus_off_q <= 1'b0;
    else if (tx_ovf) bus_off_q <= 1'b1;
  end

  assign warn_o    = (tx_cnt >= limit_q) || (rx_cnt >= limit_q);
  assign passive_o = ((tx_cnt > CNT_W'(PASSIVE_THR)) || (rx_cnt > CNT_W'(PASSIVE_THR)))
                     && !bus_off_q;
  assign bus_off_o = bus_off_q;

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      ADDR_TXCNT: reg_rdata_o = DW'(tx_cnt);
      ADDR_RXCNT: reg_rdata_o = DW'(rx_cnt);
      ADDR_LIMIT: reg_rdata_o = DW'(limit_q);
      default:    reg_rdata_o = DW'(err_capture_o);
    endcase
  end

  assert_busoff_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf |=> bus_off_o);

  assert_busoff_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !reset_mode_i) |=> bus_off_o);

  assert_busoff_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && reset_mode_i) |=> (!bus_off_o && tx_cnt == '0 && rx_cnt == '0));

  assert_frozen_busoff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !reset_mode_i) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

  assert_limit_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_mode_i |=> $stable(limit_q));

  assert_listen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_only_i && !reset_mode_i) |=> ($stable(tx_cnt) && $stable(rx_cnt)));
endmodule

// File: tb/test_can_fault_confine.sv
`timescale 1ns/1ps
module test_can_fault_confine;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reset_mode_i = 0, listen_only_i = 0;
  logic tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
  logic [1:0] err_kind_i = 0;
  logic [4:0] err_seg_i = 0;
  logic reg_wr_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o, err_capture_o;
  logic warn_o, passive_o, bus_off_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  can_fault_confine i_can_fault_confine (.*);

  // {tx_err, rx_err, tx_ok, rx_ok, listen, exp_tx, exp_rx, exp_warn, exp_passive}
  localparam logic [22:0] VEC [11] = '{
    {5'b10000, 8'd8,  8'd0, 2'b00},
    {5'b01000, 8'd8,  8'd1, 2'b00},
    {5'b11000, 8'd16, 8'd2, 2'b00},
    {5'b00100, 8'd15, 8'd2, 2'b00},
    {5'b00110, 8'd14, 8'd1, 2'b00},
    {5'b00010, 8'd14, 8'd0, 2'b00},
    {5'b00010, 8'd14, 8'd0, 2'b00},
    {5'b10100, 8'd22, 8'd0, 2'b00},
    {5'b11001, 8'd22, 8'd0, 2'b00},
    {5'b00101, 8'd22, 8'd0, 2'b00},
    {5'b01010, 8'd22, 8'd1, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #0.1;
    d = reg_rdata_o;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
    tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0; reg_wr_i = 0;
  endtask

  task automatic ev(input logic te, input logic re, input logic to, input logic ro,
                    input logic [1:0] k = 2'b00, input logic [4:0] s = 5'd0);
    tx_err_i = te; rx_err_i = re; tx_ok_i = to; rx_ok_i = ro;
    err_kind_i = k; err_seg_i = s;
    step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
  endtask

  task automatic cnts(input string req, input logic [7:0] etx, input logic [7:0] erx);
    logic [7:0] d;
    rd(2'd0, d); check({req, " tx counter"}, d, etx);
    rd(2'd1, d); check({req, " rx counter"}, d, erx);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    cnts("R1", 8'd0, 8'd0);
    rd(2'd2, d); check("R1 limit", d, 8'd96);
    rd(2'd3, d); check("R1 capture", d, 8'd0);
    check("R1 flags", {warn_o, passive_o, bus_off_o}, 3'b000);

    // R2 R3 R8 vector walk
    foreach (VEC[i]) begin
      listen_only_i = VEC[i][18];
      ev(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19]);
      listen_only_i = 0;
      cnts($sformatf("R2 R3 R8 vector %0d", i), VEC[i][17:10], VEC[i][9:2]);
      check($sformatf("R4 R5 vector %0d flags", i), {warn_o, passive_o}, VEC[i][1:0]);
    end

    // R4 warning boundary at default limit 96
    reset_mode_i = 1; wr(2'd0, 8'd88); wr(2'd1, 8'd0); reset_mode_i = 0; #0.1;
    check("R9 write in reset mode", reg_rdata_o, 8'd0);
    check("R4 below limit", warn_o, 1'b0);
    ev(1, 0, 0, 0); check("R4 equal to limit", warn_o, 1'b1);
    ev(0, 0, 1, 0); check("R4 back below limit", warn_o, 1'b0);
    cnts("R3 after warn", 8'd95, 8'd0);

    // R4 programmable limit, receive side
    reset_mode_i = 1; wr(2'd2, 8'd10); wr(2'd0, 8'd0); wr(2'd1, 8'd10); reset_mode_i = 0;
    rd(2'd2, d); check("R9 limit write", d, 8'd10);
    check("R4 rx equal to limit", warn_o, 1'b1);
    ev(0, 0, 0, 1); check("R4 rx below limit", warn_o, 1'b0);

    // R5 passive boundary
    reset_mode_i = 1; wr(2'd2, 8'd96); wr(2'd0, 8'd120); wr(2'd1, 8'd0); reset_mode_i = 0;
    ev(1, 0, 0, 0); check("R5 tx 128 passive", passive_o, 1'b1);
    ev(0, 0, 1, 0); check("R5 tx 127 not passive", passive_o, 1'b0);
    reset_mode_i = 1; wr(2'd0, 8'd0); wr(2'd1, 8'd128); reset_mode_i = 0; #0.1;
    check("R5 rx 128 passive", passive_o, 1'b1);

    // R6 bus-off entry
    reset_mode_i = 1; wr(2'd1, 8'd0); wr(2'd0, 8'd240); reset_mode_i = 0;
    ev(1, 0, 0, 0);
    cnts("R6 tx 248", 8'd248, 8'd0);
    check("R6 no bus-off at 248", bus_off_o, 1'b0);
    ev(1, 0, 0, 0);
    check("R6 bus-off set", bus_off_o, 1'b1);
    cnts("R6 saturated", 8'd255, 8'd0);
    check("R5 not passive while bus-off", passive_o, 1'b0);
    ev(0, 1, 1, 0);
    cnts("R6 frozen in bus-off", 8'd255, 8'd0);
    ev(1, 0, 0, 0);
    check("R7 bus-off sticky", bus_off_o, 1'b1);
    wr(2'd0, 8'd5);
    cnts("R9 write ignored in operating mode", 8'd255, 8'd0);

    // R7 leave bus-off, clear beats write
    reset_mode_i = 1; wr(2'd0, 8'd50);
    check("R7 bus-off cleared", bus_off_o, 1'b0);
    cnts("R7 counters cleared", 8'd0, 8'd0);
    wr(2'd0, 8'd50);
    cnts("R9 write after clear", 8'd50, 8'd0);

    // R12 events ignored in reset mode
    ev(1, 1, 0, 0, 2'b11, 5'd7);
    cnts("R12 counters in reset mode", 8'd50, 8'd0);
    rd(2'd3, d); check("R12 capture in reset mode", d, 8'd0);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R9 capture not writable", d, 8'd0);
    reset_mode_i = 0;

    // R11 capture layout
    ev(0, 1, 0, 0, 2'b10, 5'h13);
    check("R11 rx stuff capture", err_capture_o, 8'hB3);
    rd(2'd3, d); check("R10 capture read", d, 8'hB3);
    ev(1, 0, 0, 0, 2'b01, 5'h05);
    check("R11 tx form capture", err_capture_o, 8'h45);
    ev(1, 1, 0, 0, 2'b11, 5'h1F);
    check("R11 both pulses capture", err_capture_o, 8'hDF);
    cnts("R2 after capture events", 8'd66, 8'd2);

    // R9 limit write in operating mode ignored
    wr(2'd2, 8'd3);
    rd(2'd2, d); check("R9 limit locked", d, 8'd96);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule